// File: doc/BRIEF.md
# Bus Cycle Trace Classifier

This block watches the strobes, address and data lines of an 8-bit CPU bus and turns every clock phase of that bus into one trace record. The CPU clock is brought in as an ordinary input and is sampled by the system clock. Each change of its level is one sample: a rise is a high-phase sample and a fall is a low-phase sample. Each sample is given a cycle kind: opcode fetch, memory read or write, I/O read or write, refresh, interrupt acknowledge or idle. The sample is also stamped with a running bus-clock count and with the T-state number inside the current instruction.

The T-state number restarts at 1 when an opcode fetch begins and advances once per high phase after that. Low-phase samples can be emitted as well, so strobes that go active on the falling edge are seen in the T-state where they really appear. Two configuration inputs decide whether low-phase samples and refresh samples become records. A separate sensor supplies flags that mark the address or data bus as floating, and a floating field is replaced by a zero marker. Records leave through a valid/ready port. A record that meets a stalled port is dropped and sets a sticky overflow flag.

Top module: `zbus_trace`

## Requirements
- R1: Every change of `bus_clk` seen at the system clock is one sample. A rise gives phase bit `rec_phase_lo`=0 and a fall gives 1. A sample that passes the filters is on the record outputs with `rec_valid`=1 after the second rising `clk` edge that follows the cycle in which the new level is presented.
- R2: With `cfg_low_en`=0, low-phase samples produce no record. With 1, both phases do.
- R3: With `cfg_show_rfsh`=0, samples of kind refresh produce no record. With 1, they do.
- R4: `strobe_n` is active low. Its bits are [0] fetch marker, [1] memory request, [2] I/O request, [3] read, [4] write and [5] refresh. The kinds are checked in this priority order and coded as follows:
  - refresh = 6
  - fetch and I/O without memory = interrupt acknowledge, 7
  - fetch = 1
  - memory and read = 2
  - memory and write = 3
  - I/O and read = 4
  - I/O and write = 5
  - anything else = idle, 0
- R5: `rec_tstate` is 0 after reset. A high-phase sample that has the fetch marker active, when the previous high-phase sample did not, sets it to 1. Every other high-phase sample adds 1, and the count saturates at 2^T_W-1. A low-phase sample carries the value of the high phase before it.
- R6: `rec_clk_cnt` counts high-phase samples since reset, including the current one, and wraps at 2^CNT_W. Low-phase samples carry the count of the high phase before them.
- R7: `rec_first` is 1 when the sample's kind differs from the kind of the previous sample that passed the phase filter. Before any such sample, that previous kind is idle.
- R8: When `addr_float` or `data_float` is set for a sample, the matching record field reads zero and its float bit is 1.
- R9: While `rec_valid`=1 and `rec_ready`=0, the record stays unchanged. A new record that would be emitted during that time is dropped and sets `ovf`.
- R10: `ovf` stays set until a cycle with `ovf_clr`=1 and no drop. If a drop and a clear fall on the same edge, `ovf` stays 1.
- R11: After reset, `rec_valid`=0 and `ovf`=0.
- R12: An interrupt acknowledge shows kind 7, not fetch, while I/O is active with the fetch marker. The T-state keeps counting through its inserted wait states, so a seven-state acknowledge shows T1 to T7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_clk | input | 1 | CPU bus clock level |
| strobe_n | input | 6 | Active-low bus strobes, bit map in R4 |
| bus_addr | input | A_W | Address lines |
| bus_data | input | D_W | Data lines |
| addr_float | input | 1 | Address bus sensed floating |
| data_float | input | 1 | Data bus sensed floating |
| cfg_low_en | input | 1 | Emit low-phase samples |
| cfg_show_rfsh | input | 1 | Emit refresh samples |
| ovf_clr | input | 1 | Clears the overflow flag |
| rec_ready | input | 1 | Record consumer ready |
| rec_valid | output | 1 | Record valid |
| rec_clk_cnt | output | CNT_W | Bus clock count |
| rec_phase_lo | output | 1 | 1 for low-phase sample |
| rec_tstate | output | T_W | T-state number |
| rec_strobe_n | output | 6 | Sampled strobes |
| rec_addr | output | A_W | Sampled address or zero marker |
| rec_data | output | D_W | Sampled data or zero marker |
| rec_addr_float | output | 1 | Address marked floating |
| rec_data_float | output | 1 | Data marked floating |
| rec_kind | output | 3 | Cycle kind code |
| rec_first | output | 1 | First sample of a new kind |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two functions can act on the same clock edge: the drop of a record against a stalled port, which sets the flag, and the overflow clear. The bench holds `rec_ready` low and raises `ovf_clr` for exactly the cycle before the edge that loads the sample, so both act together. It then expects the flag to stay set. A second coincidence is a record being accepted on the same edge that a new one is loaded. There the bench expects the new record to replace the old one with no drop, and it compares every field against its own arithmetic model of count, T-state and kind.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int STB_W   = 6;
    localparam int SB_FETCH = 0;
    localparam int SB_MEM   = 1;
    localparam int SB_IO    = 2;
    localparam int SB_RD    = 3;
    localparam int SB_WR    = 4;
    localparam int SB_RFSH  = 5;

    typedef enum logic [2:0] {
        K_IDLE  = 3'd0,
        K_FETCH = 3'd1,
        K_MRD   = 3'd2,
        K_MWR   = 3'd3,
        K_IORD  = 3'd4,
        K_IOWR  = 3'd5,
        K_RFSH  = 3'd6,
        K_IACK  = 3'd7
    } kind_e;

    typedef struct packed {
        logic  lo;
        kind_e kind;
        logic  first;
    } meta_t;

    function automatic kind_e classify(input logic [STB_W-1:0] sn);
        logic f, mq, io, rd, wr, rf;
        kind_e k;
        f  = !sn[SB_FETCH];
        mq = !sn[SB_MEM];
        io = !sn[SB_IO];
        rd = !sn[SB_RD];
        wr = !sn[SB_WR];
        rf = !sn[SB_RFSH];
        if (rf)                  k = K_RFSH;
        else if (f && io && !mq) k = K_IACK;
        else if (f)              k = K_FETCH;
        else if (mq && rd)       k = K_MRD;
        else if (mq && wr)       k = K_MWR;
        else if (io && rd)       k = K_IORD;
        else if (io && wr)       k = K_IOWR;
        else                     k = K_IDLE;
        return k;
    endfunction

endpackage

// File: rtl/zbt_capture.sv
module zbt_capture import zbt_pkg::*; #(
    parameter int A_W = 16,
    parameter int D_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_clk,
    input  logic [STB_W-1:0] strobe_n,
    input  logic [A_W-1:0]   bus_addr,
    input  logic [D_W-1:0]   bus_data,
    input  logic             addr_float,
    input  logic             data_float,
    output logic             smp_evt,
    output logic             smp_lo,
    output logic [STB_W-1:0] smp_strobe_n,
    output logic [A_W-1:0]   smp_addr,
    output logic [D_W-1:0]   smp_data,
    output logic             smp_addr_float,
    output logic             smp_data_float
);
    logic lvl_q, lvl_qq;
    logic [A_W-1:0] addr_q;
    logic [D_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q          <= 1'b0;
            lvl_qq         <= 1'b0;
            smp_strobe_n   <= '1;
            addr_q         <= '0;
            data_q         <= '0;
            smp_addr_float <= 1'b0;
            smp_data_float <= 1'b0;
        end else begin
            lvl_q          <= bus_clk;
            lvl_qq         <= lvl_q;
            smp_strobe_n   <= strobe_n;
            addr_q         <= bus_addr;
            data_q         <= bus_data;
            smp_addr_float <= addr_float;
            smp_data_float <= data_float;
        end
    end

    assign smp_evt  = lvl_q ^ lvl_qq;
    assign smp_lo   = ~lvl_q;
    assign smp_addr = smp_addr_float ? '0 : addr_q;
    assign smp_data = smp_data_float ? '0 : data_q;
endmodule

// File: rtl/zbt_tstate.sv
module zbt_tstate import zbt_pkg::*; #(
    parameter int T_W   = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_evt,
    input  logic             smp_lo,
    input  logic [STB_W-1:0] smp_strobe_n,
    output logic [T_W-1:0]   t_cur,
    output logic [CNT_W-1:0] cnt_cur
);
    localparam logic [T_W-1:0] T_MAX = '1;

    logic [T_W-1:0]   t_reg;
    logic [CNT_W-1:0] cnt_reg;
    logic             fetch_prev;
    logic             fetch_now;
    logic             hi_evt;

    assign fetch_now = !smp_strobe_n[SB_FETCH];
    assign hi_evt    = smp_evt && !smp_lo;

    always_comb begin
        t_cur   = t_reg;
        cnt_cur = cnt_reg;
        if (hi_evt) begin
            cnt_cur = cnt_reg + 1'b1;
            if (fetch_now && !fetch_prev) t_cur = {{(T_W-1){1'b0}}, 1'b1};
            else if (t_reg != T_MAX)      t_cur = t_reg + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_reg      <= '0;
            cnt_reg    <= '0;
            fetch_prev <= 1'b0;
        end else if (hi_evt) begin
            t_reg      <= t_cur;
            cnt_reg    <= cnt_cur;
            fetch_prev <= fetch_now;
        end
    end
endmodule

// File: rtl/zbt_emit.sv
module zbt_emit import zbt_pkg::*; #(
    parameter int A_W   = 16,
    parameter int D_W   = 8,
    parameter int T_W   = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_evt,
    input  logic             smp_lo,
    input  logic [STB_W-1:0] smp_strobe_n,
    input  logic [A_W-1:0]   smp_addr,
    input  logic [D_W-1:0]   smp_data,
    input  logic             smp_addr_float,
    input  logic             smp_data_float,
    input  logic [T_W-1:0]   t_cur,
    input  logic [CNT_W-1:0] cnt_cur,
    input  logic             cfg_low_en,
    input  logic             cfg_show_rfsh,
    input  logic             ovf_clr,
    input  logic             rec_ready,
    output logic             push,
    output logic             rec_valid,
    output logic [CNT_W-1:0] rec_clk_cnt,
    output logic [T_W-1:0]   rec_tstate,
    output logic [STB_W-1:0] rec_strobe_n,
    output logic [A_W-1:0]   rec_addr,
    output logic [D_W-1:0]   rec_data,
    output logic             rec_addr_float,
    output logic             rec_data_float,
    output meta_t            rec_meta,
    output logic             ovf
);
    kind_e kind_now, kind_prev;
    logic  keep_phase, want, busy, drop;
    meta_t meta_now;

    assign kind_now   = classify(smp_strobe_n);
    assign keep_phase = !smp_lo || cfg_low_en;
    assign want       = smp_evt && keep_phase && (kind_now != K_RFSH || cfg_show_rfsh);
    assign busy       = rec_valid && !rec_ready;
    assign push       = want && !busy;
    assign drop       = want && busy;

    always_comb begin
        meta_now.lo    = smp_lo;
        meta_now.kind  = kind_now;
        meta_now.first = (kind_now != kind_prev);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_valid      <= 1'b0;
            ovf            <= 1'b0;
            kind_prev      <= K_IDLE;
            rec_clk_cnt    <= '0;
            rec_tstate     <= '0;
            rec_strobe_n   <= '1;
            rec_addr       <= '0;
            rec_data       <= '0;
            rec_addr_float <= 1'b0;
            rec_data_float <= 1'b0;
            rec_meta       <= '{lo: 1'b0, kind: K_IDLE, first: 1'b0};
        end else begin
            if (smp_evt && keep_phase) kind_prev <= kind_now;
            if (push) begin
                rec_valid      <= 1'b1;
                rec_clk_cnt    <= cnt_cur;
                rec_tstate     <= t_cur;
                rec_strobe_n   <= smp_strobe_n;
                rec_addr       <= smp_addr;
                rec_data       <= smp_data;
                rec_addr_float <= smp_addr_float;
                rec_data_float <= smp_data_float;
                rec_meta       <= meta_now;
            end else if (rec_ready) begin
                rec_valid <= 1'b0;
            end
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/zbus_trace.sv
module zbus_trace import zbt_pkg::*; #(
    parameter int A_W   = 16,
    parameter int D_W   = 8,
    parameter int T_W   = 5,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_clk,
    input  logic [5:0]       strobe_n,
    input  logic [A_W-1:0]   bus_addr,
    input  logic [D_W-1:0]   bus_data,
    input  logic             addr_float,
    input  logic             data_float,
    input  logic             cfg_low_en,
    input  logic             cfg_show_rfsh,
    input  logic             ovf_clr,
    input  logic             rec_ready,
    output logic             rec_valid,
    output logic [CNT_W-1:0] rec_clk_cnt,
    output logic             rec_phase_lo,
    output logic [T_W-1:0]   rec_tstate,
    output logic [5:0]       rec_strobe_n,
    output logic [A_W-1:0]   rec_addr,
    output logic [D_W-1:0]   rec_data,
    output logic             rec_addr_float,
    output logic             rec_data_float,
    output logic [2:0]       rec_kind,
    output logic             rec_first,
    output logic             ovf
);
    logic             smp_evt, smp_lo, smp_af, smp_df, push;
    logic [STB_W-1:0] smp_sn;
    logic [A_W-1:0]   smp_addr;
    logic [D_W-1:0]   smp_data;
    logic [T_W-1:0]   t_cur;
    logic [CNT_W-1:0] cnt_cur;
    meta_t            rec_meta;

    zbt_capture #(.A_W(A_W), .D_W(D_W)) u_cap (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .strobe_n(strobe_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .addr_float(addr_float), .data_float(data_float),
        .smp_evt(smp_evt), .smp_lo(smp_lo), .smp_strobe_n(smp_sn),
        .smp_addr(smp_addr), .smp_data(smp_data),
        .smp_addr_float(smp_af), .smp_data_float(smp_df)
    );

    zbt_tstate #(.T_W(T_W), .CNT_W(CNT_W)) u_ts (
        .clk(clk), .rst(rst), .smp_evt(smp_evt), .smp_lo(smp_lo),
        .smp_strobe_n(smp_sn), .t_cur(t_cur), .cnt_cur(cnt_cur)
    );

    zbt_emit #(.A_W(A_W), .D_W(D_W), .T_W(T_W), .CNT_W(CNT_W)) u_emit (
        .clk(clk), .rst(rst), .smp_evt(smp_evt), .smp_lo(smp_lo),
        .smp_strobe_n(smp_sn), .smp_addr(smp_addr), .smp_data(smp_data),
        .smp_addr_float(smp_af), .smp_data_float(smp_df),
        .t_cur(t_cur), .cnt_cur(cnt_cur),
        .cfg_low_en(cfg_low_en), .cfg_show_rfsh(cfg_show_rfsh),
        .ovf_clr(ovf_clr), .rec_ready(rec_ready), .push(push),
        .rec_valid(rec_valid), .rec_clk_cnt(rec_clk_cnt),
        .rec_tstate(rec_tstate), .rec_strobe_n(rec_strobe_n),
        .rec_addr(rec_addr), .rec_data(rec_data),
        .rec_addr_float(rec_addr_float), .rec_data_float(rec_data_float),
        .rec_meta(rec_meta), .ovf(ovf)
    );

    assign rec_phase_lo = rec_meta.lo;
    assign rec_kind     = rec_meta.kind;
    assign rec_first    = rec_meta.first;
endmodule

// File: rtl/zbt_checker.sv
module zbt_checker #(
    parameter int A_W   = 16,
    parameter int D_W   = 8,
    parameter int T_W   = 5,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             push,
    input logic             smp_lo,
    input logic             cfg_low_en,
    input logic             ovf_clr,
    input logic             rec_ready,
    input logic             rec_valid,
    input logic             rec_phase_lo,
    input logic [T_W-1:0]   rec_tstate,
    input logic [CNT_W-1:0] rec_clk_cnt,
    input logic [A_W-1:0]   rec_addr,
    input logic [D_W-1:0]   rec_data,
    input logic             rec_addr_float,
    input logic             rec_data_float,
    input logic             ovf
);
    p_low_filter_r2: assert property (@(posedge clk) disable iff (rst)
        push |=> (!rec_phase_lo || $past(cfg_low_en)));

    p_tstate_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
        (push && !smp_lo) |=> (rec_tstate != '0));

    p_addr_marker_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_addr_float) |-> (rec_addr == '0));

    p_data_marker_r8: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_data_float) |-> (rec_data == '0));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_tstate)
            && $stable(rec_clk_cnt) && $stable(rec_addr) && $stable(rec_phase_lo)));

    p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> $past(rec_valid && !rec_ready));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
endmodule

bind zbus_trace zbt_checker #(.A_W(A_W), .D_W(D_W), .T_W(T_W), .CNT_W(CNT_W)) i_zbt_chk (
    .clk(clk), .rst(rst), .push(push), .smp_lo(smp_lo),
    .cfg_low_en(cfg_low_en), .ovf_clr(ovf_clr), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_phase_lo(rec_phase_lo),
    .rec_tstate(rec_tstate), .rec_clk_cnt(rec_clk_cnt),
    .rec_addr(rec_addr), .rec_data(rec_data),
    .rec_addr_float(rec_addr_float), .rec_data_float(rec_data_float),
    .ovf(ovf)
);

// File: tb/test_zbus_trace.sv
`timescale 1ns/1ps
module test_zbus_trace;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_clk = 1'b0;
    logic [5:0]  strobe_n = 6'h3F;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        addr_float = 1'b0, data_float = 1'b0;
    logic        cfg_low_en = 1'b1, cfg_show_rfsh = 1'b1;
    logic        ovf_clr = 1'b0, rec_ready = 1'b1;
    logic        rec_valid, rec_phase_lo, rec_addr_float, rec_data_float, rec_first, ovf;
    logic [15:0] rec_clk_cnt;
    logic [4:0]  rec_tstate;
    logic [5:0]  rec_strobe_n;
    logic [15:0] rec_addr;
    logic [7:0]  rec_data;
    logic [2:0]  rec_kind;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    bit          e_valid = 0, e_ovf = 0, e_lo = 0, e_first = 0, e_af = 0, e_df = 0, m_pf = 0;
    logic [15:0] e_cnt = 0, m_cnt = 0, e_addr = 0;
    int          e_t = 0, m_t = 0, e_kind = 0, m_pk = 0;
    logic [7:0]  e_data = 0;
    logic [5:0]  e_sn = 6'h3F;

    always #4 clk = ~clk;

    zbus_trace i_zbus_trace (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .strobe_n(strobe_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .addr_float(addr_float), .data_float(data_float),
        .cfg_low_en(cfg_low_en), .cfg_show_rfsh(cfg_show_rfsh),
        .ovf_clr(ovf_clr), .rec_ready(rec_ready), .rec_valid(rec_valid),
        .rec_clk_cnt(rec_clk_cnt), .rec_phase_lo(rec_phase_lo),
        .rec_tstate(rec_tstate), .rec_strobe_n(rec_strobe_n),
        .rec_addr(rec_addr), .rec_data(rec_data),
        .rec_addr_float(rec_addr_float), .rec_data_float(rec_data_float),
        .rec_kind(rec_kind), .rec_first(rec_first), .ovf(ovf)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // active-high strobe list -> active-low bus: bit0 fetch,1 mem,2 io,3 rd,4 wr,5 refresh
    function automatic logic [5:0] m(input bit f, input bit mq, input bit io,
                                     input bit rd, input bit wr, input bit rf);
        return ~{rf, wr, rd, io, mq, f};
    endfunction

    function automatic int ref_kind(input logic [5:0] sn);
        logic [5:0] a;
        a = ~sn;
        if (a[5]) return 6;
        if (a[0]) return (a[2] && !a[1]) ? 7 : 1;
        if (a[1]) return a[3] ? 2 : (a[4] ? 3 : 0);
        if (a[2]) return a[3] ? 4 : (a[4] ? 5 : 0);
        return 0;
    endfunction

    task automatic compare(input string vtag);
        chk(vtag, rec_valid, e_valid);
        if (e_valid && rec_valid) begin
            chk("R1 phase", rec_phase_lo, e_lo);
            chk((e_kind == 7) ? "R12 kind" : "R4 kind", rec_kind, e_kind);
            chk((e_kind == 7) ? "R12 tstate" : "R5 tstate", rec_tstate, e_t);
            chk("R6 count", rec_clk_cnt, e_cnt);
            chk("R7 first", rec_first, e_first);
            chk("R8 addr", rec_addr, e_addr);
            chk("R8 data", rec_data, e_data);
            chk("R8 flags", {rec_addr_float, rec_data_float}, {e_af, e_df});
            chk("R1 strobes", rec_strobe_n, e_sn);
        end
        chk("R10 ovf", ovf, e_ovf);
    endtask

    // called at a falling clk edge; ends two falling edges later
    task automatic phase(input bit hi, input logic [5:0] sn, input logic [15:0] a,
                         input logic [7:0] d, input bit af, input bit df, input bit clr_late);
        bit keep, want, drop, fetch;
        int k;
        string vtag;
        bus_clk = hi; strobe_n = sn; bus_addr = a; bus_data = d;
        addr_float = af; data_float = df;
        @(negedge clk);
        if (clr_late) ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        // first edge: consumer takes the pending record
        if (e_valid && rec_ready) e_valid = 0;
        // second edge: the sample itself
        fetch = !sn[0];
        if (hi) begin
            m_cnt = m_cnt + 16'd1;
            if (fetch && !m_pf) m_t = 1;
            else if (m_t < 31) m_t = m_t + 1;
            m_pf = fetch;
        end
        k    = ref_kind(sn);
        keep = hi || cfg_low_en;
        want = keep && (k != 6 || cfg_show_rfsh);
        drop = want && e_valid && !rec_ready;
        vtag = !keep ? "R2 valid" : (!want ? "R3 valid" : "R1 valid");
        if (want && !drop) begin
            e_valid = 1; e_lo = !hi; e_kind = k; e_t = m_t; e_cnt = m_cnt;
            e_first = (k != m_pk); e_sn = sn;
            e_af = af; e_df = df;
            e_addr = af ? 16'd0 : a; e_data = df ? 8'd0 : d;
        end else if (!want && e_valid && rec_ready) e_valid = 0;
        if (keep) m_pk = k;
        if (drop) e_ovf = 1; else if (clr_late) e_ovf = 0;
        if (drop) vtag = "R9 hold";
        compare(vtag);
    endtask

    task automatic cyc(input logic [5:0] sh, input logic [5:0] sl, input logic [15:0] a,
                       input logic [7:0] d, input bit af, input bit df);
        phase(1, sh, a, d, af, df, 0);
        phase(0, sl, a, d, af, df, 0);
    endtask

    task automatic clear_ovf();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        if (e_valid && rec_ready) e_valid = 0;
        e_ovf = 0;
        chk("R10 clear", ovf, 0);
        chk("R9 valid", rec_valid, e_valid);
    endtask

    task automatic run_seq();
        logic [5:0] idle, m1, m1rd, rf, rdm, wrm, mq, iord, iowr, iack;
        idle = m(0,0,0,0,0,0); m1 = m(1,0,0,0,0,0); m1rd = m(1,1,0,1,0,0);
        rf = m(0,1,0,0,0,1); rdm = m(0,1,0,1,0,0); wrm = m(0,1,0,0,1,0);
        mq = m(0,1,0,0,0,0); iord = m(0,0,1,1,0,0); iowr = m(0,0,1,0,1,0);
        iack = m(1,0,1,0,0,0);
        // opcode fetch with refresh
        cyc(m1, m1rd, 16'h0100, 8'h00, 0, 1);
        cyc(m1rd, m1rd, 16'h0100, 8'h3E, 0, 0);
        cyc(rf, rf, 16'h0022, 8'h00, 0, 1);
        cyc(rf, idle, 16'h0022, 8'h00, 0, 1);
        // memory read
        cyc(idle, rdm, 16'h0101, 8'h00, 0, 1);
        cyc(rdm, rdm, 16'h0101, 8'h55, 0, 0);
        cyc(rdm, idle, 16'h0101, 8'h55, 0, 0);
        // memory write
        cyc(idle, mq, 16'h2000, 8'hC3, 0, 0);
        cyc(wrm, wrm, 16'h2000, 8'hC3, 0, 0);
        cyc(wrm, idle, 16'h2000, 8'hC3, 0, 0);
        // I/O read and write
        cyc(idle, idle, 16'h0003, 8'h00, 0, 1);
        cyc(iord, iord, 16'h0003, 8'h7A, 0, 0);
        cyc(iord, idle, 16'h0003, 8'h7A, 0, 0);
        cyc(iowr, iowr, 16'h0004, 8'h81, 0, 0);
        cyc(iowr, idle, 16'h0004, 8'h81, 0, 0);
        // a short fetch restarts the T-state count
        cyc(m1, m1rd, 16'h0102, 8'h00, 0, 1);
        cyc(m1rd, idle, 16'h0102, 8'hED, 0, 0);
        // interrupt acknowledge: seven high phases with the fetch marker held
        cyc(m1, m1, 16'h0103, 8'h00, 0, 1);
        cyc(m1, m1, 16'h0103, 8'h00, 0, 1);
        cyc(m1, iack, 16'h0103, 8'h00, 0, 1);
        for (int w = 0; w < 3; w++) cyc(iack, iack, 16'h0103, 8'hFE, 0, 0);
        cyc(iack, idle, 16'h0103, 8'hFE, 0, 0);
        cyc(idle, idle, 16'h0103, 8'h00, 0, 1);
        // both buses floating
        cyc(idle, idle, 16'hABCD, 8'h12, 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 valid", rec_valid, 0);
        chk("R11 ovf", ovf, 0);

        cfg_low_en = 1; cfg_show_rfsh = 1; run_seq();   // R1 R4 R5 R12
        cfg_low_en = 0; cfg_show_rfsh = 1; run_seq();   // R2
        cfg_low_en = 1; cfg_show_rfsh = 0; run_seq();   // R3
        cfg_low_en = 0; cfg_show_rfsh = 0; run_seq();

        // exhaustive sweep of all strobe codes, both phases
        cfg_low_en = 1; cfg_show_rfsh = 1;
        for (int i = 0; i < 64; i++) begin
            phase(1, i[5:0], 16'(i * 257), i[7:0], i[1], i[2], 0);
            phase(0, i[5:0], 16'(i * 257), i[7:0], i[2], i[1], 0);
        end
        cfg_show_rfsh = 0;
        for (int i = 0; i < 64; i++) begin
            phase(1, ~i[5:0], 16'(i * 3), 8'(255 - i), 0, 0, 0);
            phase(0, ~i[5:0], 16'(i * 3), 8'(255 - i), 0, 0, 0);
        end
        cfg_show_rfsh = 1;

        // R5 saturation: long run of idle after a fetch
        cyc(m(1,0,0,0,0,0), m(1,0,0,0,0,0), 16'h0001, 8'h00, 0, 1);
        for (int i = 0; i < 40; i++) cyc(6'h3F, 6'h3F, 16'h0001, 8'h00, 0, 1);

        // R9 stall: hold, drop, sticky flag
        rec_ready = 0;
        phase(1, 6'h3F, 16'h1111, 8'h11, 0, 0, 0);
        phase(0, 6'h3F, 16'h2222, 8'h22, 0, 0, 0);
        phase(1, 6'h3F, 16'h3333, 8'h33, 0, 0, 0);
        clear_ovf();
        // R10 drop and clear on one edge: flag stays set
        phase(0, 6'h3F, 16'h4444, 8'h44, 0, 0, 1);
        rec_ready = 1;
        clear_ovf();
        // R9 accept and load on the same edge: no drop
        phase(1, 6'h3E, 16'h5555, 8'h55, 0, 0, 0);
        phase(0, 6'h3E, 16'h6666, 8'h66, 0, 0, 0);
        phase(1, 6'h3F, 16'h7777, 8'h77, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule